// File: doc/BRIEF.md
# Four-Channel Match Timer

This peripheral holds four independent 32-bit counters that share one prescaler and sit behind a small memory-mapped register bus. Each channel can be enabled, held in reset, and set to count up or down. Each channel also has its own match value. When an enabled channel reaches its match value on a count tick, it can raise an interrupt flag, reload its counter to zero, or stop itself. The three actions are chosen independently by control bits for that channel.

Any register can be reached through four aliases. The low two bits of the word address select the operation: plain write, OR-set, bit clear, or bit toggle. This lets software change one field without a read-modify-write sequence. A single interrupt line is high whenever any match flag is pending.

Top module: `match_timer`

## Requirements
- R1: The word address selects a register with bits [5:2] and an operation with bits [1:0]. The operations are 0 = replace, 1 = OR written bits in, 2 = clear written bits, 3 = invert written bits. A read at any of the four aliases returns the register's value. Registers by byte offset: flags 0x00, control 0x10, direction 0x20, counters 0x30/0x40/0x50/0x60, prescaler 0x70, prescale count 0x80, match control 0x90, match values 0xA0/0xB0/0xC0/0xD0.
- R2: Control bit n (n = 0..3) enables channel n. With a prescaler of 0, an enabled channel changes its count on every clock edge after the edge that wrote the enable. A disabled channel keeps its count.
- R3: Control bit 4+n holds channel n's counter at 0 from the edge after it is set. While any such bit is set, the prescale count is also held at 0. Counting resumes on the edge after the bit is cleared.
- R4: Direction bit 4n selects channel n's direction: 0 counts up, 1 counts down. Counting down wraps from 0 to 0xFFFFFFFF.
- R5: With a prescaler value P, the prescale count (offset 0x80) steps 0..P while any channel is enabled. Enabled counters step once each time the prescale count returns from P to 0, which is once every P+1 clocks.
- R6: A match event happens on a count tick when an enabled channel's counter equals its match value. If match control bit 3n is set, the event sets flag bit n at offset 0x00. The interrupt output is high exactly while some flag is set. Flag bit 4 always reads 0.
- R7: A plain write to the flag register clears the flags written with 1 and leaves the flags written with 0 untouched. If a match sets a flag in the same cycle that a write clears it, the flag stays set.
- R8: If match control bit 3n+1 is set, a match loads the counter with 0 instead of stepping it, which gives a period of match+1 ticks.
- R9: If match control bit 3n+2 is set, a match clears enable bit n in hardware and the counter holds its value.
- R10: An up-count wrap from 0xFFFFFFFF to 0 sets no flag.
- R11: Writes to the counter and prescale-count registers are ignored.
- R12: After reset, every register, the counters, the flags and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 6 | Word address: [5:2] register, [1:0] alias operation |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | OR of all pending match flags |

## Verification
A wrong counter value shows up at the counter read port in the cycle after the faulty edge. The match event depends on that value, so the fault also reaches the flags and irq_o, either one tick early or late or not at all. A prescale counter that is off by one shifts every channel's step period, and the counter reads expose this within P+1 clocks. A lost stop action leaves the enable bit readable as 1, and the count keeps moving past the match value on the next tick. Alias decode faults show up in the first read back after a set, clear or toggle write.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int unsigned REG_IDX_W = 4;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_INVERT = 2'd3
  } alias_op_e;

  localparam logic [REG_IDX_W-1:0] IDX_FLAGS = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL  = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_DIR   = 4'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CNT0  = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_DIV   = 4'd7;
  localparam logic [REG_IDX_W-1:0] IDX_DIVC  = 4'd8;
  localparam logic [REG_IDX_W-1:0] IDX_MCTL  = 4'd9;
  localparam logic [REG_IDX_W-1:0] IDX_MATCH0 = 4'd10;

  localparam int unsigned DIR_STRIDE  = 4;
  localparam int unsigned MCTL_STRIDE = 3;
endpackage

// File: rtl/tmr_alias.sv
module tmr_alias
  import match_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alias_op_e      op_i,
  input  logic           w1c_i,
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   nxt_o
);
  always_comb begin
    unique case (op_i)
      OP_WRITE:  nxt_o = w1c_i ? (cur_i & ~wdata_i) : wdata_i;
      OP_SET:    nxt_o = cur_i | wdata_i;
      OP_CLEAR:  nxt_o = cur_i & ~wdata_i;
      default:   nxt_o = cur_i ^ wdata_i;
    endcase
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         hold_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] pc_o,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  // >= keeps the wrap alive if the divider is lowered below the running count
  assign tick_o = run_i && !hold_i && (pc_q >= div_i);
  assign pc_o   = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (hold_i)  pc_q <= '0;
    else if (run_i)   pc_q <= tick_o ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         down_i,
  input  logic         tick_i,
  input  logic [W-1:0] match_i,
  input  logic         on_rst_i,
  input  logic         on_stop_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic         active;

  assign active = en_i && !clr_i && tick_i;
  assign hit_o  = active && (cnt_q == match_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (hit_o && on_rst_i)   cnt_q <= '0;
    else if (hit_o && on_stop_i)  cnt_q <= cnt_q;
    else if (active)              cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = 2 * NUM_CH;
  localparam int unsigned MCTL_W = MCTL_STRIDE * NUM_CH;

  logic [REG_IDX_W-1:0] idx;
  alias_op_e            op;
  logic [CNT_W-1:0]     nxt;

  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_CH-1:0]    dir_q;
  logic [MCTL_W-1:0]    mctl_q;
  logic [CNT_W-1:0]     div_q;
  logic [NUM_CH-1:0]    flags_q;
  logic [CNT_W-1:0]     match_q [NUM_CH];

  logic [NUM_CH-1:0]    ch_en, ch_clr, ch_hit, on_int, on_rst, on_stop;
  logic [CNT_W-1:0]     cnt [NUM_CH];
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]     pc;
  logic                 tick;

  assign idx = addr_i[ADDR_W-1:2];
  assign op  = alias_op_e'(addr_i[1:0]);

  assign ch_en  = ctrl_q[NUM_CH-1:0];
  assign ch_clr = ctrl_q[CTRL_W-1:NUM_CH];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_mctl
    assign on_int[n]  = mctl_q[MCTL_STRIDE*n];
    assign on_rst[n]  = mctl_q[MCTL_STRIDE*n+1];
    assign on_stop[n] = mctl_q[MCTL_STRIDE*n+2];
  end

  // read mux, shared by all aliases and by the alias update
  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IDX_FLAGS: rdata_o[NUM_CH-1:0] = flags_q;
      IDX_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      IDX_DIR:   for (int n = 0; n < NUM_CH; n++) rdata_o[DIR_STRIDE*n] = dir_q[n];
      IDX_DIV:   rdata_o = div_q;
      IDX_DIVC:  rdata_o = pc;
      IDX_MCTL:  rdata_o[MCTL_W-1:0] = mctl_q;
      default: begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (idx == IDX_CNT0 + REG_IDX_W'(n))   rdata_o = cnt[n];
          if (idx == IDX_MATCH0 + REG_IDX_W'(n)) rdata_o = match_q[n];
        end
      end
    endcase
  end

  tmr_alias #(.W(CNT_W)) u_alias (
    .op_i    (op),
    .w1c_i   (idx == IDX_FLAGS),
    .cur_i   (rdata_o),
    .wdata_i (wdata_i),
    .nxt_o   (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      dir_q   <= '0;
      mctl_q  <= '0;
      div_q   <= '0;
      flags_q <= '0;
    end else begin
      ctrl_q  <= ((we_i && idx == IDX_CTRL) ? nxt[CTRL_W-1:0] : ctrl_q)
                 & ~{{NUM_CH{1'b0}}, ch_hit & on_stop};
      // hardware set wins over a same-cycle software clear
      flags_q <= ((we_i && idx == IDX_FLAGS) ? nxt[NUM_CH-1:0] : flags_q)
                 | (ch_hit & on_int);
      if (we_i && idx == IDX_DIR)
        for (int n = 0; n < NUM_CH; n++) dir_q[n] <= nxt[DIR_STRIDE*n];
      if (we_i && idx == IDX_MCTL) mctl_q <= nxt[MCTL_W-1:0];
      if (we_i && idx == IDX_DIV)  div_q  <= nxt;
    end
  end

  tmr_prescale #(.W(CNT_W)) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (|ch_en),
    .hold_i (|ch_clr),
    .div_i  (div_q),
    .pc_o   (pc),
    .tick_o (tick)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q[n] <= '0;
      else if (we_i && idx == IDX_MATCH0 + REG_IDX_W'(n)) match_q[n] <= nxt;
    end

    tmr_channel #(.W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (ch_en[n]),
      .clr_i     (ch_clr[n]),
      .down_i    (dir_q[n]),
      .tick_i    (tick),
      .match_i   (match_q[n]),
      .on_rst_i  (on_rst[n]),
      .on_stop_i (on_stop[n]),
      .cnt_o     (cnt[n]),
      .hit_o     (ch_hit[n])
    );

    assign cnt_flat[CNT_W*n +: CNT_W] = cnt[n];
  end

  assign irq_o = |flags_q;
endmodule

// File: rtl/match_timer_checker.sv
module match_timer_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       ch_en,
  input logic [NUM_CH-1:0]       ch_clr,
  input logic [NUM_CH-1:0]       ch_hit,
  input logic [NUM_CH-1:0]       on_int,
  input logic [NUM_CH-1:0]       on_rst,
  input logic [NUM_CH-1:0]       on_stop,
  input logic [NUM_CH-1:0]       flags_q,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ch_en[n] && !ch_clr[n]) |=> $stable(cnt_flat[CNT_W*n +: CNT_W]));

    p_clr_holds_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_clr[n] |=> (cnt_flat[CNT_W*n +: CNT_W] == '0));

    p_hit_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_hit[n] && on_int[n]) |=> flags_q[n]);

    p_hit_reloads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_hit[n] && on_rst[n]) |=> (cnt_flat[CNT_W*n +: CNT_W] == '0));

    p_hit_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_hit[n] && on_stop[n]) |=> !ch_en[n]);
  end
endmodule

bind match_timer match_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ch_en    (ch_en),
  .ch_clr   (ch_clr),
  .ch_hit   (ch_hit),
  .on_int   (on_int),
  .on_rst   (on_rst),
  .on_stop  (on_stop),
  .flags_q  (flags_q),
  .cnt_flat (cnt_flat)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          failures = 0;
  logic [31:0] shadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer dut (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  function automatic logic [31:0] alias_model(input logic [1:0] op,
                                              input logic [31:0] cur, input logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return cur | d;
      2'd2: return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  // byte offset plus alias operation -> word address
  function automatic logic [5:0] waddr(input logic [7:0] off, input logic [1:0] op);
    return {off[7:4], op};
  endfunction

  task automatic wr(input logic [7:0] off, input logic [1:0] op, input logic [31:0] d);
    we = 1'b1; addr = waddr(off, op); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] off, input logic [31:0] exp);
    addr = waddr(off, 2'd0);
    #1;
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s off=%h actual=%h expected=%h", req, off, rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R12 reset state
    chk("R12", 8'h00, 32'h0);
    chk("R12", 8'h10, 32'h0);
    chk("R12", 8'h30, 32'h0);
    chk("R12", 8'hC0, 32'h0);
    chk_irq("R12", 1'b0);

    // R1 random alias ops on match value of channel 2
    shadow = '0;
    for (int i = 0; i < 24; i++) begin
      logic [1:0]  op;
      logic [31:0] d;
      op = 2'($urandom_range(0, 3));
      d  = $urandom;
      wr(8'hC0, op, d);
      shadow = alias_model(op, shadow, d);
      addr = waddr(8'hC0, 2'($urandom_range(0, 3)));
      #1;
      checks++;
      if (rdata !== shadow) begin
        failures++;
        $display("FAIL R1 alias op=%0d actual=%h expected=%h", op, rdata, shadow);
      end
    end

    // R11 read-only counters
    wr(8'h30, 2'd0, 32'h1234_5678);
    chk("R11", 8'h30, 32'h0);
    wr(8'h80, 2'd1, 32'hFFFF_FFFF);
    chk("R11", 8'h80, 32'h0);

    // R2 enable, step per clock, disabled hold
    wr(8'hA0, 2'd0, 32'd100);
    wr(8'h10, 2'd1, 32'h1);
    idle(10);
    chk("R2", 8'h30, 32'd10);
    wr(8'h10, 2'd2, 32'h1);
    chk("R2", 8'h30, 32'd11);
    idle(5);
    chk("R2", 8'h30, 32'd11);

    // R3 reset bit holds counter and prescale count
    wr(8'h10, 2'd1, 32'h11);
    idle(1);
    chk("R3", 8'h30, 32'd0);
    idle(5);
    chk("R3", 8'h30, 32'd0);
    chk("R3", 8'h80, 32'd0);
    wr(8'h10, 2'd2, 32'h10);
    idle(4);
    chk("R3", 8'h30, 32'd4);

    // R4 down count with wrap
    wr(8'h10, 2'd0, 32'h10);
    idle(1);
    wr(8'h90, 2'd0, 32'h1);
    wr(8'h20, 2'd0, 32'h1);
    chk("R4", 8'h20, 32'h1);
    wr(8'h10, 2'd0, 32'h01);
    idle(3);
    chk("R4", 8'h30, 32'hFFFF_FFFD);

    // R10 up wrap gives no flag
    wr(8'h20, 2'd0, 32'h0);
    idle(5);
    chk("R10", 8'h30, 32'd1);
    chk("R10", 8'h00, 32'h0);
    chk_irq("R10", 1'b0);

    // R6 R8 periodic match with interrupt
    wr(8'h10, 2'd0, 32'h10);
    idle(1);
    wr(8'hA0, 2'd0, 32'd3);
    wr(8'h90, 2'd0, 32'b011);
    wr(8'h10, 2'd0, 32'h01);
    idle(3);
    chk("R8", 8'h30, 32'd3);
    chk("R6", 8'h00, 32'h0);
    chk_irq("R6", 1'b0);
    idle(1);
    chk("R8", 8'h30, 32'd0);
    chk("R6", 8'h00, 32'h1);
    chk_irq("R6", 1'b1);

    // R7 flag clear by writing one
    wr(8'h00, 2'd0, 32'h0);
    chk("R7", 8'h00, 32'h1);
    wr(8'h00, 2'd0, 32'h1);
    chk("R7", 8'h00, 32'h0);
    chk_irq("R7", 1'b0);
    wr(8'h00, 2'd1, 32'h10);
    chk("R6", 8'h00, 32'h0);
    wr(8'h10, 2'd0, 32'h10);
    wr(8'h00, 2'd2, 32'hF);
    chk("R7", 8'h00, 32'h0);

    // R9 stop on match
    wr(8'hA0, 2'd0, 32'd4);
    wr(8'h90, 2'd0, 32'b101);
    wr(8'h10, 2'd0, 32'h01);
    idle(6);
    chk("R9", 8'h30, 32'd4);
    chk("R9", 8'h10, 32'h0);
    chk("R9", 8'h00, 32'h1);
    idle(3);
    chk("R9", 8'h30, 32'd4);

    // R5 prescaler, two channels
    wr(8'h00, 2'd0, 32'hF);
    wr(8'h90, 2'd0, 32'h0);
    wr(8'hA0, 2'd0, 32'hFFFF_FFFF);
    wr(8'hB0, 2'd0, 32'hFFFF_FFFF);
    wr(8'h10, 2'd0, 32'h30);
    idle(1);
    wr(8'h70, 2'd0, 32'd2);
    wr(8'h10, 2'd0, 32'h03);
    idle(9);
    chk("R5", 8'h30, 32'd3);
    chk("R5", 8'h40, 32'd3);
    chk("R5", 8'h80, 32'd0);
    idle(1);
    chk("R5", 8'h80, 32'd1);
    chk("R5", 8'h30, 32'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule